// File: doc/BRIEF.md
# PHY Test Register Code Writer

This block programs a single internal register of a PHY through its serial test port. The port has five signals: an active-high clear line, a strobe clock, an operation-select enable, an 8-bit input bus and an 8-bit output bus. A caller presents a register code and a data byte and pulses `start_i`. The block then runs two phases on the port.

In the first phase it holds the enable high with the code on the bus, and lets the strobe rise and fall. The PHY latches the code on the falling strobe edge. In the second phase it holds the enable low with the data byte on the bus, and toggles the strobe again. The PHY latches the data on the rising strobe edge.

The clear line is high out of reset and drops when the first request is accepted. The PHY's output byte is captured one clock after the data-phase falling strobe edge. A one-cycle `done_o` pulse closes the transaction. Strobe high and low times are parameters of at least two system clocks each.

Top module: `phy_test_writer`

## Requirements
- R1: During and straight after reset, `testclr_o`=1, `testclk_o`=0, `testen_o`=0, `busy_o`=0, `done_o`=0 and `rdata_o`=0.
- R2: `testclr_o` falls in the cycle after the first accepted `start_i` and then stays 0. No strobe edge occurs while `testclr_o` is 1.
- R3: Address phase: while `testen_o`=1 and `testdin_o` holds the code given with `start_i`, exactly one rising and one falling edge of `testclk_o` occur.
- R4: Data phase: while `testen_o`=0 and `testdin_o` holds the data byte, exactly one rising and one falling edge of `testclk_o` occur. The address phase always comes first.
- R5: `testen_o` and `testdin_o` hold their value for at least one clock before each `testclk_o` edge and for one clock after it.
- R6: `testclk_o` stays high for `HIGH_CYC` clocks in each phase. Between the address-phase falling edge and the data-phase rising edge it stays low for `LOW_CYC`+1 clocks. Both parameters are at least 2.
- R7: A `start_i` that arrives while `busy_o`=1 is ignored: it causes no extra strobe edges and does not change the code or data being sent.
- R8: `busy_o` is 1 from the cycle after an accepted start until `done_o`. `done_o` is a one-cycle pulse, 2·`HIGH_CYC`+2·`LOW_CYC`+3 cycles after the cycle in which `start_i` was sampled.
- R9: `rdata_o` takes the value of `testdout_i` sampled at the clock edge one cycle after the data-phase falling strobe edge, and holds it until the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| code_i | input | 8 | Test register code |
| data_i | input | 8 | Data byte for the register |
| testdout_i | input | 8 | PHY test output bus |
| testclr_o | output | 1 | PHY test clear, active high |
| testclk_o | output | 1 | PHY test strobe |
| testen_o | output | 1 | Operation select: 1 address, 0 data |
| testdin_o | output | 8 | PHY test input bus |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured PHY output byte |

## Verification
On every cycle, the assertions check these properties:
- the enable and bus stay stable around each strobe edge;
- the strobe stays high for its minimum time;
- no strobe edge occurs while clear is high;
- the clear line never rises again;
- `done_o` is a single pulse.

Only the bench scenarios can show the rest:
- which byte is latched on which edge;
- the end-to-end latency;
- the exact timing of the `testdout_i` capture;
- that a stray start mid-transaction produces no extra strobe edges.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SET_A, S_HI_A, S_LO_A, S_SET_D, S_HI_D, S_LO_D, S_DONE
  } ptw_state_e;
endpackage

// File: rtl/ptw_timer.sv
module ptw_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [W-1:0] len_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == len_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || last_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/ptw_capture.sv
module ptw_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/phy_test_writer.sv
module phy_test_writer
  import ptw_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HIGH_CYC = 3,
  parameter int LOW_CYC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] code_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] testdout_i,
  output logic          testclr_o,
  output logic          testclk_o,
  output logic          testen_o,
  output logic [DW-1:0] testdin_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int MAXC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  ptw_state_e    state_q, state_d;
  logic [DW-1:0] code_q, data_q;
  logic          clr_q, fall_d_q;
  logic [CW-1:0] len;
  logic          last, adv, accept;

  assign accept = (state_q == S_IDLE) && start_i;

  // phase length in system clocks
  always_comb begin
    unique case (state_q)
      S_HI_A, S_HI_D: len = CW'(HIGH_CYC);
      S_LO_A, S_LO_D: len = CW'(LOW_CYC);
      default:        len = CW'(1);
    endcase
  end

  ptw_timer #(.W(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == S_IDLE),
    .len_i  (len),
    .last_o (last)
  );

  assign adv = last && (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    if (accept) state_d = S_SET_A;
    else if (adv) begin
      unique case (state_q)
        S_SET_A: state_d = S_HI_A;
        S_HI_A:  state_d = S_LO_A;
        S_LO_A:  state_d = S_SET_D;
        S_SET_D: state_d = S_HI_D;
        S_HI_D:  state_d = S_LO_D;
        S_LO_D:  state_d = S_DONE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      code_q   <= '0;
      data_q   <= '0;
      clr_q    <= 1'b1;
      fall_d_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      fall_d_q <= (state_q == S_HI_D) && adv;
      if (accept) begin
        code_q <= code_i;
        data_q <= data_i;
        clr_q  <= 1'b0;
      end
    end
  end

  // capture one clock after data-phase falling strobe
  ptw_capture #(.W(DW)) i_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (fall_d_q),
    .d_i   (testdout_i),
    .q_o   (rdata_o)
  );

  assign testclr_o = clr_q;
  assign testclk_o = (state_q == S_HI_A) || (state_q == S_HI_D);
  assign testen_o  = (state_q == S_SET_A) || (state_q == S_HI_A) || (state_q == S_LO_A);
  assign testdin_o = testen_o ? code_q : (state_q == S_IDLE ? '0 : data_q);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);

  a_r2_no_strobe_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    testclr_o |-> !testclk_o && !$rose(testclk_o));
  a_r2_clear_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !testclr_o |=> !testclr_o);
  a_r5_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (testclk_o != $past(testclk_o)) |-> $stable(testen_o) && $stable(testdin_o));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (testclk_o != $past(testclk_o)) |=> $stable(testen_o) && $stable(testdin_o));
  a_r6_min_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(testclk_o) |=> testclk_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r7_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(code_q) && $stable(data_q));
endmodule

// File: tb/test_phy_test_writer.sv
module test_phy_test_writer;
  localparam int HI  = 3;
  localparam int LO  = 2;
  localparam int LAT = 2 * HI + 2 * LO + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] code = '0, data = '0, tdout = 8'h5A;
  logic tclr, tclk, ten, busy, done;
  logic [7:0] tdin, rdata;

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  logic [7:0] dout_plan = '0;

  always #2 clk = ~clk;

  phy_test_writer #(.HIGH_CYC(HI), .LOW_CYC(LO)) i_phy_test_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code), .data_i(data),
    .testdout_i(tdout), .testclr_o(tclr), .testclk_o(tclk), .testen_o(ten),
    .testdin_o(tdin), .busy_o(busy), .done_o(done), .rdata_o(rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on latching strobe edges, checks timing
  logic p_clk = 1'b0, p_en = 1'b0, hold_chk = 1'b0, dout_next = 1'b0;
  logic [7:0] p_din = '0;
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dout_next) begin tdout <= ~dout_plan; dout_next <= 1'b0; end
      if (hold_chk) begin
        chk("R5 hold", {ten, tdin}, {p_en, p_din});
        hold_chk <= 1'b0;
      end
      if (tclk != p_clk) begin
        chk("R5 setup", {ten, tdin}, {p_en, p_din});
        chk("R2 no strobe while clear", tclr, 1'b0);
        hold_chk <= 1'b1;
        if (!tclk) chk("R6 high time", run, HI);
        if (tclk && !ten) chk("R6 low gap", run, LO + 1);
        if ((!tclk && ten) || (tclk && !ten)) begin
          if (exp_q.size() == 0) chk("R7 unexpected strobe", 1, 0);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(ten ? "R3 address latch" : "R4 data latch", {ten, tdin}, e);
          end
        end
        if (!tclk && !ten) begin tdout <= dout_plan; dout_next <= 1'b1; end
        run <= 1;
      end else run <= run + 1;
      p_clk <= tclk; p_en <= ten; p_din <= tdin;
    end
  end

  task automatic run_txn(input logic [7:0] c, input logic [7:0] d,
                         input logic [7:0] dout, input bit stray);
    int k;
    exp_q.push_back({1'b1, c});
    exp_q.push_back({1'b0, d});
    dout_plan = dout;
    @(negedge clk); start = 1'b1; code = c; data = d;
    @(negedge clk); start = 1'b0; code = ~c; data = ~d;
    k = 1;
    chk("R8 busy after start", busy, 1'b1);
    chk("R2 clear released", tclr, 1'b0);
    while (!done && k < 100) begin
      if (stray && k == 4) begin start = 1'b1; code = 8'hEE; data = 8'hEE; end
      if (stray && k == 5) start = 1'b0;
      @(negedge clk); k++;
    end
    chk("R8 done latency", k, LAT);
    chk("R9 captured testdout", rdata, dout);
    @(negedge clk);
    chk("R8 done one cycle", {done, busy}, 2'b00);
    chk("R9 rdata held", rdata, dout);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {tclr, tclk, ten, busy, done, rdata}, {5'b10000, 8'h00});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {tclr, tclk, ten, busy, done}, 5'b10000);
    run_txn(8'h44, 8'h74, 8'hC3, 1'b0);
    run_txn(8'hA5, 8'h5A, 8'h0F, 1'b0);
    run_txn(8'h00, 8'hFF, 8'h81, 1'b1);   // R7 stray start mid-transaction
    run_txn(8'hFF, 8'h00, 8'h3C, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 no leftover strobes", exp_q.size(), 0);
    chk("R2 clear stays low", tclr, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule